// File: doc/BRIEF.md
# AHB-Lite Master Ingress Stage

This block sits between a single AHB-Lite master and a shared interconnect. An address phase cannot be stalled, so the block registers every NONSEQ or SEQ transfer into a holding register on the edge that ends its address phase. It then offers the held transfer downstream as a request and keeps the master in wait states until an arbitration stage takes it and the slave finishes the data phase.

IDLE and BUSY address phases never reach the slave. The block answers them itself with a zero-wait OKAY. There is no combinational path from the master's address signals to the slave side. The cost is one extra cycle on every active transfer. The gain is that the address path is fully registered for timing.

Top module: `ahbl_ingress_stage`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `m_readyout` is 1, `m_resp` is 0 (OKAY) and `req_valid` is 0.
- R2: An address phase with `m_trans` = 2'b00 (IDLE), accepted while `m_readyout` is 1, is followed by a data phase with `m_readyout` = 1 and `m_resp` = 0, and no request is raised.
- R3: An address phase with `m_trans` = 2'b01 (BUSY) gets the same local zero-wait OKAY and is never forwarded as a request.
- R4: An address phase with `m_trans` = 2'b10 (NONSEQ) or 2'b11 (SEQ), accepted while `m_readyout` is 1, raises `req_valid` in the next cycle. The request's address, trans, write, size, burst and protection fields equal the values the master drove in that address phase.
- R5: While `req_valid` is 1, `m_readyout` is 0 and `m_resp` is 0. Every active transfer therefore sees at least one wait state, and a transfer whose request waits A cycles before acceptance and whose slave adds S wait states sees A+1+S wait states in total.
- R6: While a request is pending, changes on the master's address-phase inputs are ignored. The request fields stay stable, and no extra request appears.
- R7: A request is accepted in a cycle where `req_valid` and `req_accept` are both 1. `req_valid` is 0 in the following cycle.
- R8: In each cycle of the slave data phase (the cycles after acceptance, up to and including the cycle in which `s_ready` is 1), `m_readyout` equals `s_ready` and `m_resp` equals `s_resp`.
- R9: A new active transfer whose address phase coincides with the final slave data-phase cycle of the previous transfer is captured on that same edge, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | ADDR_W | Master address |
| m_trans | input | 2 | Master transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| m_write | input | 1 | Master write flag |
| m_size | input | SIZE_W | Master transfer size |
| m_burst | input | BURST_W | Master burst type |
| m_prot | input | PROT_W | Master protection attributes |
| m_readyout | output | 1 | Ready returned to the master |
| m_resp | output | 1 | Response returned to the master (0 = OKAY) |
| req_valid | output | 1 | Held transfer is pending downstream |
| req_accept | input | 1 | Downstream takes the held transfer this cycle |
| req_addr | output | ADDR_W | Held address |
| req_trans | output | 2 | Held transfer type |
| req_write | output | 1 | Held write flag |
| req_size | output | SIZE_W | Held size |
| req_burst | output | BURST_W | Held burst |
| req_prot | output | PROT_W | Held protection |
| s_ready | input | 1 | Slave ready during the forwarded data phase |
| s_resp | input | 1 | Slave response during the forwarded data phase |

## Verification
The hardest case to reach is a capture on the same edge that completes the slave's data phase. The bench gets there by presenting the next NONSEQ or SEQ while the previous transfer is still waiting, with the downstream model accepting immediately and the slave answering without waits. A second hard case is a reset that lands while a request is pending. The bench reaches it by slowing acceptance to many cycles and pulling reset mid-wait. To check that the master's inputs are ignored while a request is pending, the bench drives an inverted address and a fresh NONSEQ during the hold cycle. The scoreboard then confirms that only the original fields ever reach acceptance.

// File: rtl/ahbl_ingress_pkg.sv
package ahbl_ingress_pkg;

  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  // master-facing data phase state
  typedef enum logic [1:0] {
    DP_FREE  = 2'b00,  // local zero-wait OKAY
    DP_HOLD  = 2'b01,  // request pending, local wait states
    DP_SLAVE = 2'b10   // slave response forwarded
  } dp_state_e;

  localparam logic RESP_OKAY = 1'b0;

  // NONSEQ and SEQ carry bit 1 set
  function automatic logic trans_active(input logic [1:0] t);
    return t[1];
  endfunction

endpackage

// File: rtl/ahbl_xfer_hold.sv
module ahbl_xfer_hold #(
  parameter int W          = 8,
  parameter bit RESET_DATA = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         accept,
  input  logic [W-1:0] d,
  output logic         pending,
  output logic [W-1:0] q
);

  logic pend_d;

  always_comb begin
    pend_d = pending;
    if (cap) begin
      pend_d = 1'b1;
    end else if (accept) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      pending <= pend_d;
    end
  end

  generate
    if (RESET_DATA) begin : g_rst_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (cap) begin
          q <= d;
        end
      end
    end else begin : g_plain_data
      always_ff @(posedge clk) begin
        if (cap) begin
          q <= d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/ahbl_dp_ctrl.sv
module ahbl_dp_ctrl
  import ahbl_ingress_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic accept,
  input  logic s_ready,
  input  logic s_resp,
  output logic readyout,
  output logic resp
);

  dp_state_e state_q;
  dp_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      DP_FREE: begin
        if (cap) state_d = DP_HOLD;
      end
      DP_HOLD: begin
        if (accept) state_d = DP_SLAVE;
      end
      DP_SLAVE: begin
        if (s_ready) state_d = cap ? DP_HOLD : DP_FREE;
      end
      default: state_d = DP_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DP_FREE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    readyout = 1'b1;
    resp     = RESP_OKAY;
    case (state_q)
      DP_HOLD: begin
        readyout = 1'b0;
      end
      DP_SLAVE: begin
        readyout = s_ready;
        resp     = s_resp;
      end
      default: begin
        readyout = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/ahbl_ingress_stage.sv
module ahbl_ingress_stage
  import ahbl_ingress_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 3,
  parameter int BURST_W    = 3,
  parameter int PROT_W     = 4,
  parameter bit RESET_DATA = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  m_addr,
  input  logic [1:0]         m_trans,
  input  logic               m_write,
  input  logic [SIZE_W-1:0]  m_size,
  input  logic [BURST_W-1:0] m_burst,
  input  logic [PROT_W-1:0]  m_prot,
  output logic               m_readyout,
  output logic               m_resp,
  output logic               req_valid,
  input  logic               req_accept,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [1:0]         req_trans,
  output logic               req_write,
  output logic [SIZE_W-1:0]  req_size,
  output logic [BURST_W-1:0] req_burst,
  output logic [PROT_W-1:0]  req_prot,
  input  logic               s_ready,
  input  logic               s_resp
);

  localparam int XFER_W = ADDR_W + 2 + 1 + SIZE_W + BURST_W + PROT_W;

  logic              cap;
  logic              accept;
  logic [XFER_W-1:0] xfer_d;
  logic [XFER_W-1:0] xfer_q;

  // an address phase ends only on an edge where the master sees ready high
  assign cap    = m_readyout & trans_active(m_trans);
  assign accept = req_valid & req_accept;
  assign xfer_d = {m_addr, m_trans, m_write, m_size, m_burst, m_prot};

  ahbl_xfer_hold #(
    .W          (XFER_W),
    .RESET_DATA (RESET_DATA)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .accept  (accept),
    .d       (xfer_d),
    .pending (req_valid),
    .q       (xfer_q)
  );

  assign {req_addr, req_trans, req_write, req_size, req_burst, req_prot} = xfer_q;

  ahbl_dp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (cap),
    .accept   (accept),
    .s_ready  (s_ready),
    .s_resp   (s_resp),
    .readyout (m_readyout),
    .resp     (m_resp)
  );

endmodule

// File: rtl/ahbl_ingress_chk.sv
module ahbl_ingress_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] m_addr,
  input logic [1:0]        m_trans,
  input logic              m_write,
  input logic              m_readyout,
  input logic              m_resp,
  input logic              req_valid,
  input logic              req_accept,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_trans,
  input logic              req_write,
  input logic              s_ready,
  input logic              s_resp
);

  // independent tracker of the forwarded slave data phase
  logic fwd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b0;
    end else if (req_valid && req_accept) begin
      fwd_q <= 1'b1;
    end else if (fwd_q && s_ready) begin
      fwd_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (m_readyout && !m_resp && !req_valid); // R1
    end
  end

  AST_IDLE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_readyout && m_trans == 2'b00) |=> (m_readyout && m_resp == 1'b0 && !req_valid)); // R2

  AST_BUSY_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_readyout && m_trans == 2'b01) |=> (m_readyout && m_resp == 1'b0 && !req_valid)); // R3

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_readyout && m_trans[1]) |=> (req_valid && req_addr == $past(m_addr)
                                    && req_write == $past(m_write) && req_trans == $past(m_trans))); // R4

  AST_WAIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!m_readyout && m_resp == 1'b0)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_accept) |=> (req_valid && $stable(req_addr) && $stable(req_trans) && $stable(req_write))); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_accept) |=> !req_valid); // R7

  AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_q |-> (m_readyout == s_ready && m_resp == s_resp)); // R8

endmodule

bind ahbl_ingress_stage ahbl_ingress_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m_addr     (m_addr),
  .m_trans    (m_trans),
  .m_write    (m_write),
  .m_readyout (m_readyout),
  .m_resp     (m_resp),
  .req_valid  (req_valid),
  .req_accept (req_accept),
  .req_addr   (req_addr),
  .req_trans  (req_trans),
  .req_write  (req_write),
  .s_ready    (s_ready),
  .s_resp     (s_resp)
);

// File: tb/ahbl_ingress_stage_test.sv
module ahbl_ingress_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] m_addr;
  logic [1:0]    m_trans;
  logic          m_write;
  logic [2:0]    m_size;
  logic [2:0]    m_burst;
  logic [3:0]    m_prot;
  logic          m_readyout, m_resp;
  logic          req_valid, req_accept;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_trans;
  logic          req_write;
  logic [2:0]    req_size, req_burst;
  logic [3:0]    req_prot;
  logic          s_ready, s_resp;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahbl_ingress_stage uut (
    .clk(clk), .rst_n(rst_n),
    .m_addr(m_addr), .m_trans(m_trans), .m_write(m_write), .m_size(m_size),
    .m_burst(m_burst), .m_prot(m_prot), .m_readyout(m_readyout), .m_resp(m_resp),
    .req_valid(req_valid), .req_accept(req_accept), .req_addr(req_addr),
    .req_trans(req_trans), .req_write(req_write), .req_size(req_size),
    .req_burst(req_burst), .req_prot(req_prot), .s_ready(s_ready), .s_resp(s_resp)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    trans;
    logic          write;
    logic [2:0]    size;
    logic [2:0]    burst;
    logic [3:0]    prot;
  } item_t;

  item_t expq[$];
  int    total = 0;
  int    bad = 0;
  int    acc_wait = 0;
  int    slv_wait = 0;
  bit    err_mode = 1'b0;
  bit    dp_now = 1'b0;
  bit    prev_acc = 1'b0;
  bit    done = 1'b0;
  int    last_wait = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // downstream arbitration and slave model, drives just after each edge
  initial begin
    int acnt;
    int wcnt;
    bit nxt_dp;
    acnt = 0; wcnt = 0; nxt_dp = 1'b0;
    req_accept = 1'b0; s_ready = 1'b1; s_resp = 1'b0;
    forever begin
      @(posedge clk); #1;
      req_accept = 1'b0; s_ready = 1'b1; s_resp = 1'b0;
      if (!rst_n) begin
        acnt = 0; wcnt = 0; nxt_dp = 1'b0; dp_now = 1'b0;
      end else begin
        dp_now = nxt_dp;
        nxt_dp = 1'b0;
        if (dp_now) begin
          s_resp = err_mode;
          if (wcnt < slv_wait) begin
            s_ready = 1'b0; wcnt++; nxt_dp = 1'b1;
          end else begin
            wcnt = 0;
          end
        end
        if (req_valid) begin
          if (acnt >= acc_wait) begin
            req_accept = 1'b1; acnt = 0; nxt_dp = 1'b1;
          end else begin
            acnt++;
          end
        end
      end
    end
  end

  // monitor: scoreboard pops at acceptance, forwarding checked each slave cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_acc = 1'b0;
    end else begin
      if (prev_acc) check(!req_valid, "R7", "req_valid after accept", req_valid, 0);
      prev_acc = req_valid && req_accept;
      if (dp_now) begin
        check(m_readyout == s_ready, "R8", "forwarded ready", m_readyout, s_ready);
        check(m_resp == s_resp, "R8", "forwarded resp", m_resp, s_resp);
      end
      if (req_valid && req_accept) begin
        item_t e;
        if (expq.size() == 0) begin
          check(1'b0, "R6", "request with nothing expected", req_addr, 0);
        end else begin
          e = expq.pop_front();
          check(req_addr == e.addr, "R4", "req_addr", req_addr, e.addr);
          check({req_trans, req_write, req_size, req_burst, req_prot} ==
                {e.trans, e.write, e.size, e.burst, e.prot}, "R4", "req attributes",
                {req_trans, req_write, req_size, req_burst, req_prot},
                {e.trans, e.write, e.size, e.burst, e.prot});
        end
      end
    end
  end

  // driver: present one address phase, starting just after a clock edge
  task automatic issue(input logic [AW-1:0] a, input logic [1:0] t, input logic w,
                       input logic [2:0] sz, input logic [2:0] bu, input logic [3:0] pr,
                       input string tag);
    int n;
    item_t e;
    n = 0;
    m_addr = a; m_trans = t; m_write = w; m_size = sz; m_burst = bu; m_prot = pr;
    if (t[1]) begin
      e = '{addr: a, trans: t, write: w, size: sz, burst: bu, prot: pr};
      expq.push_back(e);
    end
    @(negedge clk);
    while (!m_readyout) begin
      n++;
      @(negedge clk);
    end
    last_wait = n;
    @(posedge clk); #1;
    if (t[1]) begin
      // hold cycle: junk that must be ignored (R6)
      m_trans = 2'b10; m_addr = ~a; m_write = ~w; m_prot = ~pr;
    end else begin
      m_trans = 2'b00;
    end
    @(negedge clk);
    if (t[1]) begin
      check(req_valid == 1'b1, tag, "req_valid after capture", req_valid, 1);
      check(m_readyout == 1'b0, "R5", "wait state after capture", m_readyout, 0);
    end else begin
      check(req_valid == 1'b0, tag, "no request for idle/busy", req_valid, 0);
      check(m_readyout == 1'b1 && m_resp == 1'b0, tag, "local zero-wait OKAY",
            {m_readyout, m_resp}, 2'b10);
    end
    @(posedge clk); #1;
    m_trans = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_addr = '0; m_trans = 2'b00; m_write = 1'b0; m_size = 3'd2; m_burst = 3'd0; m_prot = 4'h3;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(m_readyout == 1'b1, "R1", "ready in reset", m_readyout, 1);
    check(m_resp == 1'b0, "R1", "resp in reset", m_resp, 0);
    check(req_valid == 1'b0, "R1", "req_valid in reset", req_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(m_readyout == 1'b1 && !req_valid, "R1", "after reset release",
          {m_readyout, req_valid}, 2'b10);

    issue(32'h0000_0000, 2'b00, 1'b0, 3'd2, 3'd0, 4'h3, "R2");
    issue(32'h0000_0040, 2'b01, 1'b0, 3'd2, 3'd0, 4'h3, "R3");

    // slow grant and slow slave: waits = 2 + 1 + 1
    acc_wait = 2; slv_wait = 1;
    issue(32'h1000_0004, 2'b10, 1'b1, 3'd2, 3'd0, 4'h1, "R4");
    issue(32'h0, 2'b00, 1'b0, 3'd0, 3'd0, 4'h0, "R2");
    check(last_wait == 3, "R5", "remaining wait states", last_wait, 3);

    // back-to-back burst with immediate grant and zero-wait slave
    acc_wait = 0; slv_wait = 0;
    issue(32'h2000_0000, 2'b10, 1'b0, 3'd2, 3'd3, 4'h2, "R4");
    issue(32'h2000_0004, 2'b11, 1'b0, 3'd2, 3'd3, 4'h2, "R9");
    check(last_wait == 0, "R9", "capture on completing edge", last_wait, 0);
    issue(32'h2000_0008, 2'b11, 1'b0, 3'd2, 3'd3, 4'h2, "R9");
    check(last_wait == 0, "R9", "capture on completing edge", last_wait, 0);
    issue(32'h2000_000C, 2'b11, 1'b0, 3'd2, 3'd3, 4'h2, "R9");
    issue(32'h0, 2'b01, 1'b0, 3'd0, 3'd0, 4'h0, "R3");
    check(last_wait == 0, "R5", "single local wait only", last_wait, 0);

    // error response forwarded through slave waits
    err_mode = 1'b1; slv_wait = 2;
    issue(32'h3000_0010, 2'b10, 1'b1, 3'd1, 3'd0, 4'hA, "R4");
    issue(32'h0, 2'b00, 1'b0, 3'd0, 3'd0, 4'h0, "R2");
    check(last_wait == 2, "R8", "slave wait states forwarded", last_wait, 2);
    err_mode = 1'b0; slv_wait = 0;

    // BUSY inside a burst, then the burst continues
    issue(32'h4000_0000, 2'b10, 1'b0, 3'd2, 3'd3, 4'h3, "R4");
    issue(32'h4000_0004, 2'b01, 1'b0, 3'd2, 3'd3, 4'h3, "R3");
    issue(32'h4000_0004, 2'b11, 1'b0, 3'd2, 3'd3, 4'h3, "R4");
    issue(32'h0, 2'b00, 1'b0, 3'd0, 3'd0, 4'h0, "R2");

    // reset while a request is pending
    acc_wait = 20;
    issue(32'h5000_0000, 2'b10, 1'b1, 3'd2, 3'd0, 4'h3, "R4");
    repeat (2) @(negedge clk);
    check(req_valid == 1'b1, "R6", "still pending before reset", req_valid, 1);
    rst_n = 1'b0;
    #1;
    check(m_readyout == 1'b1 && m_resp == 1'b0, "R1", "reset clears wait",
          {m_readyout, m_resp}, 2'b10);
    check(req_valid == 1'b0, "R1", "reset clears pending", req_valid, 0);
    expq.delete();
    acc_wait = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    issue(32'h6000_0020, 2'b10, 1'b0, 3'd0, 3'd1, 4'h0, "R4");
    issue(32'h0, 2'b00, 1'b0, 3'd0, 3'd0, 4'h0, "R2");

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R6", "all expected requests seen once", expq.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule